// File: doc/BRIEF.md
# Checkpointed Group Commit Tracker

This block stands in for a large reorder buffer. It keeps a small ring of checkpoints, and each checkpoint owns a contiguous group of in-flight instructions. Every instruction is registered at dispatch, either against the youngest live checkpoint or, when the dispatch asks for it (at a branch, or at a load when the core's heuristic selects loads), against a newly opened checkpoint. An instruction stops being tracked as soon as it reports completion, whatever the order of completions. Architectural commit happens one whole checkpoint at a time. The oldest checkpoint retires once its group has drained and a younger checkpoint exists to take over as the restore point.

On an exception or misspeculation the core names the checkpoint just before the faulting instruction. The block discards every younger checkpoint, empties the named one, makes it the youngest again, and reports the restore point. When a branch resolves early, the youngest checkpoint can be folded into its older neighbour, which frees its table entry. Register and memory snapshots are kept outside the block and are referred to only by the checkpoint index.

A small state machine controls dispatch. In `ST_RUN` every dispatch is accepted. In `ST_FULL` all entries are live: requests that open a checkpoint are refused and plain dispatches still go through. `ST_RECOVER` lasts one cycle after a rollback and refuses all dispatch. Every state takes the same transitions. An accepted rollback leads to `ST_RECOVER`. Otherwise, an occupancy equal to the table size leads to `ST_FULL`, and any other occupancy leads to `ST_RUN`.

Top module: `ckpt_commit_unit`

## Requirements
- R1: After reset, exactly one checkpoint is live: index 0 with start tag 0 and nothing outstanding. `stall`, `commit_valid` and `rb_valid` are low, and a plain dispatch is given index 0.
- R2: `disp_ckpt_id` is combinational. When `disp_new` is high it is the allocation pointer, which is the entry after the youngest in ring order (index N_CKPT-1 wraps to 0). Otherwise it is the youngest live index. An accepted new-checkpoint dispatch stores `disp_seq` as the start tag and counts the dispatching instruction as that checkpoint's first outstanding instruction.
- R3: A completion decrements the outstanding count of checkpoint `cmpl_id`, in any order. A completion naming a dead entry, or an entry whose count is zero, has no effect.
- R4: A checkpoint commits when three conditions hold at a clock edge: it is the oldest live entry, its count is zero, and a younger entry is live. In the next cycle `commit_valid` pulses for one cycle with its index and start tag. Indices commit in strict ring order.
- R5: `stall` is high while all N_CKPT entries are live. During that time a dispatch with `disp_new` high is dropped, and a plain dispatch is accepted into the youngest entry.
- R6: When `flush_valid` names a live entry, all younger entries are freed, the named entry's count is cleared, and it becomes the youngest. In the next cycle `rb_valid` pulses with its index and start tag. Any dispatch, completion, merge or commit in that same cycle is ignored. A flush naming a dead entry is ignored.
- R7: For the one cycle after a rollback, `stall` is high and every dispatch is dropped.
- R8: `merge_valid` frees the youngest entry only if four conditions hold: more than one entry is live, the youngest has a zero count, `disp_valid` is low, and a commit in the same cycle would not leave the table empty. Otherwise the merge is ignored.
- R9: No checkpoint commits while its outstanding count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | An instruction is dispatched this cycle |
| disp_new | input | 1 | The dispatch opens a new checkpoint |
| disp_seq | input | SEQ_W | Sequence tag of the dispatched instruction |
| disp_ckpt_id | output | IDX_W | Checkpoint index the dispatched instruction belongs to |
| cmpl_valid | input | 1 | An instruction completed |
| cmpl_id | input | IDX_W | Checkpoint index of the completed instruction |
| merge_valid | input | 1 | Fold the youngest checkpoint into its older neighbour |
| flush_valid | input | 1 | Roll back to a checkpoint |
| flush_id | input | IDX_W | Checkpoint to restore |
| stall | output | 1 | Table full or recovering |
| commit_valid | output | 1 | One-cycle checkpoint commit pulse |
| commit_id | output | IDX_W | Index of the committed checkpoint |
| commit_seq | output | SEQ_W | Start tag of the committed checkpoint |
| rb_valid | output | 1 | One-cycle rollback pulse |
| rb_id | output | IDX_W | Index of the restored checkpoint |
| rb_seq | output | SEQ_W | Start tag of the restored checkpoint |

## Verification
The hardest case to reach is a rollback that lands while the ring has wrapped and is full, together with a commit and a merge that compete in the same cycle. Such a rollback has to free a run of entries that crosses index 0. The stimulus first opens checkpoints until the table is full and keeps pushing new-checkpoint requests into the stall. It then drains groups in random order so that the oldest entries retire and the pointers wrap. After that it mixes dispatch, merge attempts and rollbacks aimed at randomly chosen live entries. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/ckpt_pkg.sv
`timescale 1ns/1ps
package ckpt_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_FULL    = 2'd1,
        ST_RECOVER = 2'd2
    } cu_state_t;
endpackage

// File: rtl/ckpt_slot.sv
`timescale 1ns/1ps
// One checkpoint table entry: liveness, start tag and outstanding count.
module ckpt_slot #(
    parameter int SEQ_W       = 16,
    parameter int CNT_W       = 8,
    parameter bit RESET_VALID = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [SEQ_W-1:0] alloc_seq,
    input  logic             inc,
    input  logic             dec,
    input  logic             kill,
    input  logic             clear,
    output logic             valid,
    output logic [SEQ_W-1:0] seq,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= RESET_VALID;
            seq   <= '0;
            cnt   <= '0;
        end else if (alloc) begin
            valid <= 1'b1;
            seq   <= alloc_seq;
            cnt   <= CNT_W'(1);
        end else if (kill) begin
            valid <= 1'b0;
            cnt   <= '0;
        end else if (clear) begin
            cnt   <= '0;
        end else if (inc && !dec) begin
            cnt   <= cnt + CNT_W'(1);
        end else if (dec && !inc) begin
            cnt   <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/ckpt_fsm.sv
`timescale 1ns/1ps
// Dispatch gate: run, full or recovering.
module ckpt_fsm
    import ckpt_pkg::*;
#(
    parameter int N_CKPT = 4,
    parameter int OCC_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_ok,
    input  logic [OCC_W-1:0] occ_next,
    output cu_state_t        state,
    output logic             stall
);
    cu_state_t state_nx;
    logic      will_fill;

    assign will_fill = (occ_next == OCC_W'(N_CKPT));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (flush_ok)       state_nx = ST_RECOVER;
                else if (will_fill) state_nx = ST_FULL;
                else                state_nx = ST_RUN;
            end
            ST_FULL: begin
                if (flush_ok)       state_nx = ST_RECOVER;
                else if (will_fill) state_nx = ST_FULL;
                else                state_nx = ST_RUN;
            end
            ST_RECOVER: begin
                if (flush_ok)       state_nx = ST_RECOVER;
                else if (will_fill) state_nx = ST_FULL;
                else                state_nx = ST_RUN;
            end
            default:                state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_RUN:     stall = 1'b0;
            ST_FULL:    stall = 1'b1;
            ST_RECOVER: stall = 1'b1;
            default:    stall = 1'b1;
        endcase
    end
endmodule

// File: rtl/ckpt_commit_unit.sv
`timescale 1ns/1ps
// Ring of checkpoints with out-of-order instruction release and in-order group commit.
module ckpt_commit_unit
    import ckpt_pkg::*;
#(
    parameter  int N_CKPT = 4,
    parameter  int SEQ_W  = 16,
    parameter  int CNT_W  = 8,
    localparam int IDX_W  = $clog2(N_CKPT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic             disp_new,
    input  logic [SEQ_W-1:0] disp_seq,
    output logic [IDX_W-1:0] disp_ckpt_id,
    input  logic             cmpl_valid,
    input  logic [IDX_W-1:0] cmpl_id,
    input  logic             merge_valid,
    input  logic             flush_valid,
    input  logic [IDX_W-1:0] flush_id,
    output logic             stall,
    output logic             commit_valid,
    output logic [IDX_W-1:0] commit_id,
    output logic [SEQ_W-1:0] commit_seq,
    output logic             rb_valid,
    output logic [IDX_W-1:0] rb_id,
    output logic [SEQ_W-1:0] rb_seq
);
    localparam int OCC_W = IDX_W + 1;

    logic [IDX_W-1:0] head_q, tail_q, youngest, dist_f;
    logic [OCC_W-1:0] occ_q, occ_nx;
    logic [N_CKPT-1:0]             slot_valid;
    logic [N_CKPT-1:0][SEQ_W-1:0]  slot_seq;
    logic [N_CKPT-1:0][CNT_W-1:0]  slot_cnt;
    cu_state_t state;
    logic flush_ok, commit_ok, disp_acc, new_acc, plain_acc, cpl_ok, merge_ok;

    assign youngest     = tail_q - IDX_W'(1);
    assign dist_f       = flush_id - head_q;
    assign disp_ckpt_id = disp_new ? tail_q : youngest;

    assign flush_ok  = flush_valid && slot_valid[flush_id];
    assign commit_ok = !flush_ok && slot_valid[head_q] &&
                       (slot_cnt[head_q] == '0) && (occ_q > OCC_W'(1));
    assign disp_acc  = !flush_ok && disp_valid && (state != ST_RECOVER) &&
                       !(disp_new && state == ST_FULL);
    assign new_acc   = disp_acc && disp_new;
    assign plain_acc = disp_acc && !disp_new;
    assign cpl_ok    = !flush_ok && cmpl_valid && slot_valid[cmpl_id] &&
                       (slot_cnt[cmpl_id] != '0);
    assign merge_ok  = !flush_ok && merge_valid && !disp_valid &&
                       (occ_q > OCC_W'(1)) && (slot_cnt[youngest] == '0) &&
                       !(commit_ok && occ_q == OCC_W'(2));

    always_comb begin
        if (flush_ok)
            occ_nx = {1'b0, dist_f} + OCC_W'(1);
        else
            occ_nx = occ_q + OCC_W'(new_acc) - OCC_W'(commit_ok) - OCC_W'(merge_ok);
    end

    for (genvar i = 0; i < N_CKPT; i++) begin : g_slot
        logic [IDX_W-1:0] dist_i;
        logic             kill_i;
        assign dist_i = IDX_W'(i) - head_q;
        assign kill_i = (commit_ok && head_q == IDX_W'(i)) ||
                        (merge_ok && youngest == IDX_W'(i)) ||
                        (flush_ok && slot_valid[i] && (dist_i > dist_f));
        ckpt_slot #(
            .SEQ_W      (SEQ_W),
            .CNT_W      (CNT_W),
            .RESET_VALID(i == 0)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (new_acc && tail_q == IDX_W'(i)),
            .alloc_seq(disp_seq),
            .inc      (plain_acc && youngest == IDX_W'(i)),
            .dec      (cpl_ok && cmpl_id == IDX_W'(i)),
            .kill     (kill_i),
            .clear    (flush_ok && flush_id == IDX_W'(i)),
            .valid    (slot_valid[i]),
            .seq      (slot_seq[i]),
            .cnt      (slot_cnt[i])
        );
    end

    ckpt_fsm #(.N_CKPT(N_CKPT), .OCC_W(OCC_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_ok(flush_ok),
        .occ_next(occ_nx),
        .state   (state),
        .stall   (stall)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q       <= '0;
            tail_q       <= IDX_W'(1);
            occ_q        <= OCC_W'(1);
            commit_valid <= 1'b0;
            commit_id    <= '0;
            commit_seq   <= '0;
            rb_valid     <= 1'b0;
            rb_id        <= '0;
            rb_seq       <= '0;
        end else begin
            occ_q        <= occ_nx;
            commit_valid <= commit_ok;
            rb_valid     <= flush_ok;
            if (flush_ok) begin
                tail_q <= flush_id + IDX_W'(1);
                rb_id  <= flush_id;
                rb_seq <= slot_seq[flush_id];
            end else begin
                head_q <= head_q + IDX_W'(commit_ok);
                tail_q <= tail_q + IDX_W'(new_acc) - IDX_W'(merge_ok);
            end
            if (commit_ok) begin
                commit_id  <= head_q;
                commit_seq <= slot_seq[head_q];
            end
        end
    end
endmodule

// File: rtl/ckpt_commit_checks.sv
`timescale 1ns/1ps
module ckpt_commit_checks #(
    parameter  int N_CKPT = 4,
    parameter  int CNT_W  = 8,
    localparam int IDX_W  = $clog2(N_CKPT)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         commit_valid,
    input logic [IDX_W-1:0]             commit_id,
    input logic                         rb_valid,
    input logic                         stall,
    input logic [N_CKPT-1:0]            slot_valid,
    input logic [N_CKPT-1:0][CNT_W-1:0] slot_cnt
);
    logic [IDX_W-1:0]             exp_head;
    logic [N_CKPT-1:0][CNT_W-1:0] cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_head <= '0;
            cnt_d    <= '0;
        end else begin
            cnt_d <= slot_cnt;
            if (commit_valid) exp_head <= exp_head + IDX_W'(1);
        end
    end

    assert_live_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid != '0);
    assert_commit_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> commit_id == exp_head);
    assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&slot_valid) |-> stall);
    assert_rb_no_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> !commit_valid);
    assert_recover_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> stall);
    assert_drained_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> cnt_d[commit_id] == '0);
endmodule

bind ckpt_commit_unit ckpt_commit_checks #(.N_CKPT(N_CKPT), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_valid(commit_valid),
    .commit_id   (commit_id),
    .rb_valid    (rb_valid),
    .stall       (stall),
    .slot_valid  (slot_valid),
    .slot_cnt    (slot_cnt)
);

// File: tb/ckpt_commit_unit_test.sv
`timescale 1ns/1ps
module ckpt_commit_unit_test;
    localparam int N = 4;
    localparam int SW = 16;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 0, disp_new = 0, cmpl_valid = 0, merge_valid = 0, flush_valid = 0;
    logic [SW-1:0] disp_seq = '0;
    logic [IW-1:0] cmpl_id = '0, flush_id = '0;
    logic [IW-1:0] disp_ckpt_id, commit_id, rb_id;
    logic [SW-1:0] commit_seq, rb_seq;
    logic stall, commit_valid, rb_valid;

    always #4 clk = ~clk;

    ckpt_commit_unit #(.N_CKPT(N), .SEQ_W(SW), .CNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_new(disp_new),
        .disp_seq(disp_seq), .disp_ckpt_id(disp_ckpt_id), .cmpl_valid(cmpl_valid),
        .cmpl_id(cmpl_id), .merge_valid(merge_valid), .flush_valid(flush_valid),
        .flush_id(flush_id), .stall(stall), .commit_valid(commit_valid),
        .commit_id(commit_id), .commit_seq(commit_seq), .rb_valid(rb_valid),
        .rb_id(rb_id), .rb_seq(rb_seq));

    int total = 0, bad = 0;
    bit done = 0;
    // behavioural model
    bit mv[N]; int ms[N]; int mc[N];
    int head, tail, occ, mst;   // mst: 0 run, 1 full, 2 recover
    bit e_cv, e_rv; int e_cid, e_cseq, e_rid, e_rseq;
    int outq[$];
    int seqc = 1;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ymd();
        return (tail + N - 1) % N;
    endfunction

    task automatic model_step();
        int y;
        bit commit, dacc, merge, cok;
        e_cv = 0; e_rv = 0;
        if (flush_valid && mv[flush_id]) begin
            // R6: discard younger, restore target
            int i = (int'(flush_id) + 1) % N;
            e_rv = 1; e_rid = flush_id; e_rseq = ms[flush_id];
            while (i != tail) begin mv[i] = 0; mc[i] = 0; i = (i + 1) % N; end
            mc[flush_id] = 0;
            tail = (int'(flush_id) + 1) % N;
            occ = ((int'(flush_id) - head + N) % N) + 1;
            mst = 2;
            for (int k = outq.size() - 1; k >= 0; k--)
                if (!mv[outq[k]] || outq[k] == int'(flush_id)) outq.delete(k);
            return;
        end
        y = ymd();
        commit = mv[head] && mc[head] == 0 && occ > 1;           // R4 R9
        dacc = disp_valid && mst != 2 && !(disp_new && mst == 1); // R5 R7
        merge = merge_valid && !disp_valid && occ > 1 && mc[y] == 0 &&
                !(commit && occ == 2);                            // R8
        cok = cmpl_valid && mv[cmpl_id] && mc[cmpl_id] > 0;       // R3
        if (cok) mc[cmpl_id]--;
        if (commit) begin
            e_cv = 1; e_cid = head; e_cseq = ms[head];
            mv[head] = 0; head = (head + 1) % N; occ--;
        end
        if (dacc) begin
            if (disp_new) begin
                mv[tail] = 1; ms[tail] = disp_seq; mc[tail] = 1;
                outq.push_back(tail); tail = (tail + 1) % N; occ++;
            end else begin
                mc[y]++; outq.push_back(y);
            end
        end
        if (merge) begin mv[y] = 0; tail = y; occ--; end
        mst = (occ == N) ? 1 : 0;
    endtask

    task automatic check_regs();
        chk("R3 R4 R9 commit_valid", commit_valid, e_cv);
        if (e_cv) begin
            chk("R4 commit_id", commit_id, e_cid);
            chk("R4 commit_seq", commit_seq, e_cseq);
        end
        chk("R6 rb_valid", rb_valid, e_rv);
        if (e_rv) begin
            chk("R6 rb_id", rb_id, e_rid);
            chk("R6 rb_seq", rb_seq, e_rseq);
        end
        chk("R5 R7 stall", stall, mst != 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < N; i++) begin mv[i] = (i == 0); ms[i] = 0; mc[i] = 0; end
        head = 0; tail = 1; occ = 1; mst = 0; e_cv = 0; e_rv = 0;
        #1;
        chk("R1 reset stall", stall, 0);
        chk("R1 reset commit_valid", commit_valid, 0);
        chk("R1 reset rb_valid", rb_valid, 0);
        chk("R1 reset plain id", disp_ckpt_id, 0);
        for (int c = 0; c < 4000; c++) begin
            disp_valid = 0; disp_new = 0; cmpl_valid = 0; merge_valid = 0; flush_valid = 0;
            if (c < 20) begin
                disp_valid = 1; disp_new = 1;          // fill table, push into stall
            end else if (c < 60) begin
                if (outq.size() > 0) cmpl_valid = 1;   // drain out of order
            end else if (c < 100) begin
                disp_valid = ($urandom % 3) == 0;
                disp_new = disp_valid;
                cmpl_valid = outq.size() > 0 && ($urandom % 2);
                merge_valid = ($urandom % 2);
            end else begin
                disp_valid = ($urandom % 2);
                disp_new = ($urandom % 4) == 0;
                cmpl_valid = outq.size() > 0 && ($urandom % 10) < 7;
                merge_valid = ($urandom % 10) == 0;
                flush_valid = ($urandom % 30) == 0;
            end
            if (disp_valid && !disp_new && mc[ymd()] > 200) disp_valid = 0;
            disp_seq = SW'(seqc); seqc++;
            if (cmpl_valid) begin
                int ix = $urandom % outq.size();
                cmpl_id = IW'(outq[ix]); outq.delete(ix);
            end else if (($urandom % 8) == 0) begin
                cmpl_valid = 1; cmpl_id = IW'($urandom);   // stray completion
            end
            if (flush_valid) begin
                if (($urandom % 5) == 0) flush_id = IW'($urandom);
                else flush_id = IW'((head + ($urandom % occ)) % N);
            end
            #1;
            chk("R2 R8 disp_ckpt_id", disp_ckpt_id, disp_new ? tail : ymd());
            model_step();
            @(negedge clk);
            check_regs();
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule